// File: doc/BRIEF.md
# Tone Guard-Time Steering and Code Latch

This block sits behind a dual-tone classifier and decides when a detected key press is real. The classifier raises a detect flag whenever it sees a valid row/column frequency pair and supplies the 2-bit row and 2-bit column indices. Instead of an analog timing network, two programmable counters, counted in milliseconds from a tick derived from the system clock, qualify the flag. Presence must last for the present guard time before the key is registered. Absence must last for the absent guard time before the registration ends. Bursts that are too short are discarded. Gaps that are too short are bridged as dropouts.

On registration, the row/column pair is turned into a 4-bit key code and stored in a latch. One clock later the delayed strobe rises. The stored code stays available after the tone ends and until the next registration. An output-enable input gates the code bus, and a separate valid flag stands in for the high-impedance state. A guard status output shows when either guard timer is running.

Top module: `steer_guard_latch`

## Requirements
- R1: With the detect flag sampled high on clock edges k through k+P*D, where P is the present guard time in ms and D is the clocks per ms tick, the code latch takes the encoded key at edge k+P*D and the delayed strobe rises at edge k+P*D+1.
- R2: A detect burst that falls before edge k+P*D is rejected. Code and strobe are unchanged, and the present timer restarts from zero on the next burst.
- R3: While a key is registered, a detect gap shorter than the absent guard time is bridged. The strobe stays high, the code is unchanged, and no new registration happens when the flag returns, even with different indices.
- R4: With the flag sampled low on edges m through m+A*D after registration (A is the absent guard time in ms), the strobe falls at edge m+A*D.
- R5: The code bus changes one clock before the delayed strobe rises, and the code never changes while the strobe is high.
- R6: Key encoding, row 0..3 = low tones ascending, column 0..3 = high tones ascending. Row 0 gives 1,2,3,A. Row 1 gives 4,5,6,B. Row 2 gives 7,8,9,C. Row 3 gives *,0,#,D. Digits 1..9 map to binary 1..9. Key 0 maps to 1010, * to 1011, # to 1100, A to 1101, B to 1110, C to 1111, and D to 0000.
- R7: With the output enable low, the code bus reads 0000 and the bus-valid flag is low. Registration still updates the latch, and the new code appears as soon as the enable rises.
- R8: After the strobe falls, the last code stays on the bus until the next registration.
- R9: Once absence has been validated, the next tone registers with full present qualification.
- R10: If the flag returns on exactly the edge where the absent timer would expire, the return wins. The key stays registered and the strobe stays high.
- R11: After reset the strobe and guard status are low, and the latch holds 0000.
- R12: The guard status output is high while the present or the absent timer is running, and low when idle or when a key is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_i | input | 1 | Early detect flag from the tone classifier |
| row_i | input | 2 | Low-group tone index |
| col_i | input | 2 | High-group tone index |
| oe_i | input | 1 | Code bus enable |
| pres_ms_i | input | GW | Present guard time in ms |
| abs_ms_i | input | GW | Absent guard time in ms |
| q_o | output | 4 | Gated key code |
| q_en_o | output | 1 | Code bus valid (low means the bus is released) |
| dstrb_o | output | 1 | Delayed strobe |
| gt_o | output | 1 | Guard timer running |

## Verification
Two decisions can land on the same clock edge: the absent timer completing its last tick, and the detect flag coming back. The bench provokes this by holding the flag low for exactly A*D edges and raising it in time for the expiry edge. It then judges the outcome at the ports: the strobe must stay high and the latched code must not change. A second collision comes from toggling the output enable around a registration. Latch contents written while the bus is disabled must appear at once when the enable rises.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_QPRES = 3'd1,
    ST_LOAD  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_QABS  = 3'd4
  } steer_st_e;
endpackage

// File: rtl/steer_tick.sv
// Millisecond prescaler. It restarts from zero whenever run is low,
// so that each guard window starts on a known phase.
module steer_tick #(
  parameter int DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/steer_keyenc.sv
// Row/column index pair to keypad code.
module steer_keyenc (
  input  logic [1:0] row,
  input  logic [1:0] col,
  output logic [3:0] code
);
  always_comb begin
    if (col == 2'd3) begin
      // Letter column: 13 + row, and row 3 wraps to 0000
      code = 4'd13 + {2'b00, row};
    end else if (row == 2'd3) begin
      case (col)
        2'd0:    code = 4'd11;
        2'd1:    code = 4'd10;
        default: code = 4'd12;
      endcase
    end else begin
      code = ({2'b00, row} * 4'd3) + {2'b00, col} + 4'd1;
    end
  end
endmodule

// File: rtl/steer_fsm.sv
// Presence/absence qualification state machine with one shared ms counter.
module steer_fsm
  import steer_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det,
  input  logic          tick,
  input  logic [GW-1:0] pres_ms,
  input  logic [GW-1:0] abs_ms,
  output steer_st_e     state,
  output logic          load
);
  steer_st_e     st_q, st_d;
  logic [GW-1:0] ms_q, ms_d;

  always_comb begin
    st_d = st_q;
    ms_d = ms_q;
    unique case (st_q)
      ST_IDLE: begin
        ms_d = '0;
        if (det) st_d = (pres_ms == '0) ? ST_LOAD : ST_QPRES;
      end
      ST_QPRES: begin
        if (!det) begin
          st_d = ST_IDLE;
          ms_d = '0;
        end else if (tick) begin
          if (ms_q == pres_ms - GW'(1)) begin
            st_d = ST_LOAD;
            ms_d = '0;
          end else begin
            ms_d = ms_q + GW'(1);
          end
        end
      end
      ST_LOAD: begin
        st_d = ST_HOLD;
        ms_d = '0;
      end
      ST_HOLD: begin
        ms_d = '0;
        if (!det) st_d = (abs_ms == '0) ? ST_IDLE : ST_QABS;
      end
      ST_QABS: begin
        // A returning flag outranks a completing absent timer
        if (det) begin
          st_d = ST_HOLD;
          ms_d = '0;
        end else if (tick) begin
          if (ms_q == abs_ms - GW'(1)) begin
            st_d = ST_IDLE;
            ms_d = '0;
          end else begin
            ms_d = ms_q + GW'(1);
          end
        end
      end
      default: begin
        st_d = ST_IDLE;
        ms_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ms_q <= '0;
    end else begin
      st_q <= st_d;
      ms_q <= ms_d;
    end
  end

  assign state = st_q;
  assign load  = (st_d == ST_LOAD) && (st_q != ST_LOAD);
endmodule

// File: rtl/steer_guard_latch.sv
module steer_guard_latch
  import steer_pkg::*;
#(
  parameter int TICK_DIV = 125000,
  parameter int GW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det_i,
  input  logic [1:0]    row_i,
  input  logic [1:0]    col_i,
  input  logic          oe_i,
  input  logic [GW-1:0] pres_ms_i,
  input  logic [GW-1:0] abs_ms_i,
  output logic [3:0]    q_o,
  output logic          q_en_o,
  output logic          dstrb_o,
  output logic          gt_o
);
  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  steer_st_e state;
  logic      load, tick, run;
  logic [3:0] enc_code;
  logic [3:0] code_q, code_d;

  assign run = (state == ST_QPRES) || (state == ST_QABS);

  steer_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .run  (run),
    .tick (tick)
  );

  steer_fsm #(.GW(GW)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .det    (det_i),
    .tick   (tick),
    .pres_ms(pres_ms_i),
    .abs_ms (abs_ms_i),
    .state  (state),
    .load   (load)
  );

  steer_keyenc u_enc (
    .row (row_i),
    .col (col_i),
    .code(enc_code)
  );

  // Code latch with explicit enable
  always_comb begin
    code_d = code_q;
    if (load) code_d = enc_code;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) code_q <= 4'd0;
    else             code_q <= code_d;
  end

  assign dstrb_o = (state == ST_HOLD) || (state == ST_QABS);
  assign gt_o    = run;
  assign q_en_o  = oe_i;
  assign q_o     = oe_i ? code_q : 4'd0;
endmodule

// File: rtl/steer_guard_chk.sv
module steer_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       det_i,
  input logic       oe_i,
  input logic [3:0] q_o,
  input logic       q_en_o,
  input logic       dstrb_o,
  input logic       gt_o,
  input logic [3:0] code_q
);
  // R1: a rise of the strobe follows a detect flag seen two edges earlier
  p_rise_after_det_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dstrb_o) |-> $past(det_i, 2));

  // R4: the strobe only falls after an edge with the flag low
  p_fall_after_abs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dstrb_o) |-> !$past(det_i));

  // R5: the latch is already settled when the strobe rises
  p_setup_before_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dstrb_o) |-> $stable(code_q));

  // R3: no registration while a key is held, including across dropouts
  p_hold_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dstrb_o && $past(dstrb_o) |-> $stable(code_q));

  // R7: a released bus carries no code
  p_bus_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en_o |-> (q_o == 4'd0) && !oe_i);

  // R12: timing a guard window and holding a key never overlap with a fresh rise
  p_guard_vs_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dstrb_o) |-> !gt_o);
endmodule

bind steer_guard_latch steer_guard_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .det_i  (det_i),
  .oe_i   (oe_i),
  .q_o    (q_o),
  .q_en_o (q_en_o),
  .dstrb_o(dstrb_o),
  .gt_o   (gt_o),
  .code_q (code_q)
);

// File: tb/sim_steer_guard_latch.sv
module sim_steer_guard_latch;
  localparam int D  = 4;
  localparam int GW = 8;
  localparam int P  = 5;
  localparam int A  = 3;
  localparam int PD = P * D;
  localparam int AD = A * D;

  // {row, col, expected code}
  localparam logic [7:0] VEC [16] = '{
    8'h01, 8'h12, 8'h23, 8'h3D,
    8'h44, 8'h55, 8'h66, 8'h7E,
    8'h87, 8'h98, 8'hA9, 8'hBF,
    8'hCB, 8'hDA, 8'hEC, 8'hF0
  };

  logic clk = 1'b0;
  logic rst_n;
  logic det_i;
  logic [1:0] row_i, col_i;
  logic oe_i;
  logic [GW-1:0] pres_ms_i, abs_ms_i;
  logic [3:0] q_o;
  logic q_en_o, dstrb_o, gt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  steer_guard_latch #(.TICK_DIV(D), .GW(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .det_i(det_i), .row_i(row_i), .col_i(col_i),
    .oe_i(oe_i), .pres_ms_i(pres_ms_i), .abs_ms_i(abs_ms_i),
    .q_o(q_o), .q_en_o(q_en_o), .dstrb_o(dstrb_o), .gt_o(gt_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Raise the flag and check the registration timing (R1, R5, R12)
  task automatic reg_key(input logic [1:0] r, input logic [1:0] c, input logic [3:0] exp);
    row_i = r; col_i = c; det_i = 1'b1;
    wait_n(PD);
    chk("R1 strobe low before guard end", dstrb_o, 0);
    chk("R12 guard status during present window", gt_o, 1);
    wait_n(1);
    chk("R6 code latched", q_o, exp);
    chk("R5 strobe still low in setup cycle", dstrb_o, 0);
    wait_n(1);
    chk("R1 strobe high", dstrb_o, 1);
    chk("R12 guard status low while held", gt_o, 0);
  endtask

  // Drop the flag and check absence validation (R4, R8)
  task automatic release_key(input logic [3:0] exp);
    det_i = 1'b0;
    wait_n(AD);
    chk("R4 strobe held during absent window", dstrb_o, 1);
    wait_n(1);
    chk("R4 strobe low after absent window", dstrb_o, 0);
    chk("R8 code retained after release", q_o, exp);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; det_i = 1'b0; row_i = '0; col_i = '0; oe_i = 1'b1;
    pres_ms_i = GW'(P); abs_ms_i = GW'(A);
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    chk("R11 reset strobe", dstrb_o, 0);
    chk("R11 reset guard status", gt_o, 0);
    chk("R11 reset code", q_o, 4'd0);
    chk("R7 bus valid with enable high", q_en_o, 1);

    // R2: burst one cycle too short
    row_i = 2'd1; col_i = 2'd1; det_i = 1'b1;
    wait_n(PD);
    det_i = 1'b0;
    wait_n(3);
    chk("R2 short burst no strobe", dstrb_o, 0);
    chk("R2 short burst code unchanged", q_o, 4'd0);
    chk("R12 guard status idle", gt_o, 0);

    // R6, R8, R9: table walk, each key after a validated pause
    for (int i = 0; i < 16; i++) begin
      reg_key(VEC[i][7:6], VEC[i][5:4], VEC[i][3:0]);
      release_key(VEC[i][3:0]);
      wait_n(2);
      chk("R9 idle between keys", dstrb_o, 0);
    end

    // R3: dropout shorter than the absent guard, back with other indices
    reg_key(2'd0, 2'd0, 4'd1);
    det_i = 1'b0;
    wait_n(5);
    chk("R12 guard status in absent window", gt_o, 1);
    row_i = 2'd2; col_i = 2'd2; det_i = 1'b1;
    wait_n(PD + 3);
    chk("R3 strobe bridged", dstrb_o, 1);
    chk("R3 no new registration", q_o, 4'd1);

    // R10: return lands on the absent expiry edge
    det_i = 1'b0;
    wait_n(AD);
    det_i = 1'b1;
    wait_n(2);
    chk("R10 return wins over expiry", dstrb_o, 1);
    chk("R10 code kept", q_o, 4'd1);
    release_key(4'd1);
    wait_n(2);

    // R7: registration with the bus disabled
    oe_i = 1'b0;
    wait_n(1);
    chk("R7 bus zero when disabled", q_o, 4'd0);
    chk("R7 valid low when disabled", q_en_o, 0);
    row_i = 2'd2; col_i = 2'd1; det_i = 1'b1;
    wait_n(PD + 2);
    chk("R7 strobe while disabled", dstrb_o, 1);
    chk("R7 bus still zero", q_o, 4'd0);
    oe_i = 1'b1;
    #1;
    chk("R7 latched code appears", q_o, 4'd8);
    chk("R7 valid high", q_en_o, 1);
    release_key(4'd8);

    // R9: immediate next key after validated pause
    reg_key(2'd3, 2'd1, 4'd10);
    release_key(4'd10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule